// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block sits between a CPU's address bus and the on-chip memories and turns each 16-bit address into one of three region selects. The regions are an on-chip RAM, a 160-byte control-register block and a fixed EEPROM window. The RAM and the register block can each be moved to the start of any 4K page. Their page numbers are held in an 8-bit placement register, which itself lives inside the register block. For an address that falls in the register block, the block also gives the byte offset within the block. When the address is the placement register's own slot, the block returns that register's value on the read data output.

The placement register has two write limits. It accepts a single write, and only while a bus-clock counter that starts at reset is still below its limit. Once either limit is reached, writes have no effect and the register can only be read. The EEPROM window appears only while the EEPROM-enable input is high.

All inputs are plain per-cycle bus signals with no handshake. The selects, the offset and the read data are combinational in the address. A write strobe takes effect at the rising clock edge.

Top module: `mmap_decoder`

## Requirements
- R1: After reset the placement register reads 0x00, so both the RAM and the register block sit in page 0.
- R2: `sel_ram` is high when address bits 15:12 equal placement bits 7:4 and address bits 11:0 are below RAM_BYTES (default 1024). Only a higher-priority region can suppress it.
- R3: `sel_reg` is high when address bits 15:12 equal placement bits 3:0 and address bits 11:0 are below 0xA0. While `sel_reg` is high, `reg_ofs` equals address bits 7:0. Otherwise `reg_ofs` is 0.
- R4: A write, meaning `wr_en` high while register offset 0x3D is selected, loads `wdata` into the placement register. It is accepted at any of the first WIN_CYCLES (default 64) rising edges after reset is released. Those are edge indices 0 to 63.
- R5: A write at edge index WIN_CYCLES or later leaves the placement register unchanged.
- R6: After one write has been accepted, any later write leaves the placement register unchanged, even inside the window.
- R7: The placement register sits at offset 0x3D of the register block and moves with the block. While that offset is selected, `rdata` shows the register's current value. At every other address `rdata` is 0.
- R8: With `ee_en` at 0, `sel_ee` is never high. With `ee_en` at 1, addresses from EE_BASE (default 0xE000) up to EE_BASE+EE_BYTES-1 (default 0xE7FF) select the EEPROM.
- R9: At most one select is high at a time. The register block wins over the RAM and over the EEPROM, and the RAM wins over the EEPROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data |
| ee_en | input | 1 | EEPROM-enable configuration bit |
| sel_ram | output | 1 | RAM region selected |
| sel_reg | output | 1 | Register block selected |
| sel_ee | output | 1 | EEPROM region selected |
| reg_ofs | output | 8 | Byte offset inside the register block |
| rdata | output | 8 | Placement register readback |

## Verification
The bench uses the default parameters: a 1 KB RAM, a 64-cycle window and a 2 KB EEPROM window at 0xE000. With a 64-cycle window, both window edges (index 63 and index 64) can be reached in a few dozen idle cycles after a fresh reset. With the EEPROM in page 0xE, a single placement value of 0xEE stacks all three regions on the same page. One address sweep then exercises the whole priority order and the RAM's upper bound.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_REG  = 2'd1,
    RGN_RAM  = 2'd2,
    RGN_EE   = 2'd3
  } region_e;
endpackage

// File: rtl/mmap_page_match.sv
// Hit when the address lies in a page-aligned region of SIZE bytes.
module mmap_page_match #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int SIZE   = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  localparam int OFS_W      = ADDR_W - PAGE_W;
  localparam int PAGE_BYTES = 1 << OFS_W;

  logic page_eq;
  assign page_eq = (addr[ADDR_W-1:OFS_W] == page);

  generate
    if (SIZE >= PAGE_BYTES) begin : g_full
      assign hit = page_eq;
    end else begin : g_part
      localparam logic [OFS_W:0] LIMIT = (OFS_W+1)'(SIZE);
      assign hit = page_eq && ({1'b0, addr[OFS_W-1:0]} < LIMIT);
    end
  endgenerate
endmodule

// File: rtl/mmap_init_reg.sv
// Write-once placement register, open only during a window after reset.
module mmap_init_reg #(
  parameter int MAP_W      = 8,
  parameter int WIN_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [MAP_W-1:0] wdata,
  output logic [MAP_W-1:0] map_q
);
  localparam int                CNT_W   = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             used_q;
  logic             win_open;
  logic             take;

  assign win_open = (cnt_q != CNT_MAX);
  assign take     = wr_req && win_open && !used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (win_open) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      used_q <= 1'b0;
    end else if (take) begin
      map_q  <= wdata;
      used_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mmap_prio.sv
// Resolves overlapping hits: register block, then RAM, then EEPROM.
module mmap_prio
  import mmap_pkg::*;
(
  input  logic    hit_reg,
  input  logic    hit_ram,
  input  logic    hit_ee,
  output region_e rgn
);
  always_comb begin
    if (hit_reg)      rgn = RGN_REG;
    else if (hit_ram) rgn = RGN_RAM;
    else if (hit_ee)  rgn = RGN_EE;
    else              rgn = RGN_NONE;
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 4,
  parameter int RAM_BYTES  = 1024,
  parameter int REG_BYTES  = 160,
  parameter int EE_BASE    = 'hE000,
  parameter int EE_BYTES   = 2048,
  parameter int WIN_CYCLES = 64,
  parameter int MAP_OFS    = 'h3D,
  localparam int MAP_W     = 2 * PAGE_W,
  localparam int ROFS_W    = $clog2(REG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [MAP_W-1:0]  wdata,
  input  logic              ee_en,
  output logic              sel_ram,
  output logic              sel_reg,
  output logic              sel_ee,
  output logic [ROFS_W-1:0] reg_ofs,
  output logic [MAP_W-1:0]  rdata
);
  localparam logic [ADDR_W:0]  EE_LO    = (ADDR_W+1)'(EE_BASE);
  localparam logic [ADDR_W:0]  EE_HI    = (ADDR_W+1)'(EE_BASE + EE_BYTES);
  localparam logic [ROFS_W-1:0] MAP_SLOT = ROFS_W'(MAP_OFS);

  logic [MAP_W-1:0] map_q;
  logic             hit_ram, hit_reg, hit_ee;
  logic             map_hit;
  region_e          rgn;

  mmap_page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZE(RAM_BYTES)) u_ram_match (
    .addr (addr),
    .page (map_q[MAP_W-1:PAGE_W]),
    .hit  (hit_ram)
  );

  mmap_page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZE(REG_BYTES)) u_reg_match (
    .addr (addr),
    .page (map_q[PAGE_W-1:0]),
    .hit  (hit_reg)
  );

  assign hit_ee = ee_en && ({1'b0, addr} >= EE_LO) && ({1'b0, addr} < EE_HI);

  mmap_prio u_prio (
    .hit_reg (hit_reg),
    .hit_ram (hit_ram),
    .hit_ee  (hit_ee),
    .rgn     (rgn)
  );

  assign sel_reg = (rgn == RGN_REG);
  assign sel_ram = (rgn == RGN_RAM);
  assign sel_ee  = (rgn == RGN_EE);
  assign reg_ofs = sel_reg ? addr[ROFS_W-1:0] : '0;

  assign map_hit = sel_reg && (addr[ROFS_W-1:0] == MAP_SLOT);
  assign rdata   = map_hit ? map_q : '0;

  mmap_init_reg #(.MAP_W(MAP_W), .WIN_CYCLES(WIN_CYCLES)) u_init (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (wr_en && map_hit),
    .wdata  (wdata),
    .map_q  (map_q)
  );
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk #(
  parameter int RAM_BYTES  = 1024,
  parameter int REG_BYTES  = 160,
  parameter int WIN_CYCLES = 64,
  parameter int MAP_OFS    = 'h3D
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        wr_en,
  input logic        ee_en,
  input logic        sel_ram,
  input logic        sel_reg,
  input logic        sel_ee,
  input logic [7:0]  reg_ofs,
  input logic [7:0]  rdata,
  input logic [7:0]  map_q
);
  int cyc;
  logic taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= 0;
      taken <= 1'b0;
    end else begin
      if (cyc < WIN_CYCLES) cyc <= cyc + 1;
      if (wr_en && sel_reg && (int'(reg_ofs) == MAP_OFS) && (cyc < WIN_CYCLES))
        taken <= 1'b1;
    end
  end

  AST_RAM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ram |-> (addr[15:12] == map_q[7:4]) && (int'(addr[11:0]) < RAM_BYTES)); // R2
  AST_REG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reg |-> (int'(reg_ofs) < REG_BYTES)); // R3
  AST_WINDOW_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == WIN_CYCLES) |=> $stable(map_q)); // R5
  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> $stable(map_q)); // R6
  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_reg && int'(reg_ofs) == MAP_OFS) |-> (rdata == map_q)); // R7
  AST_EE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_en |-> !sel_ee); // R8
  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ram, sel_reg, sel_ee})); // R9
endmodule

bind mmap_decoder mmap_decoder_chk #(
  .RAM_BYTES(RAM_BYTES), .REG_BYTES(REG_BYTES),
  .WIN_CYCLES(WIN_CYCLES), .MAP_OFS(MAP_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .ee_en(ee_en),
  .sel_ram(sel_ram), .sel_reg(sel_reg), .sel_ee(sel_ee),
  .reg_ofs(reg_ofs), .rdata(rdata), .map_q(map_q)
);

// File: tb/test_mmap_decoder.sv
module test_mmap_decoder;
  localparam int RAMB = 1024;
  localparam int REGB = 160;
  localparam int EEB  = 'hE000;
  localparam int EES  = 2048;
  localparam int WIN  = 64;
  localparam int SLOT = 'h3D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        ee_en = 1'b0;
  logic        sel_ram, sel_reg, sel_ee;
  logic [7:0]  reg_ofs, rdata;

  int checks = 0;
  int errors = 0;
  int m_map, m_cnt;
  bit m_taken;

  always #2 clk = ~clk;

  mmap_decoder #(.RAM_BYTES(RAMB), .REG_BYTES(REGB), .EE_BASE(EEB),
                 .EE_BYTES(EES), .WIN_CYCLES(WIN), .MAP_OFS(SLOT)) i_mmap_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .ee_en(ee_en), .sel_ram(sel_ram), .sel_reg(sel_reg), .sel_ee(sel_ee),
    .reg_ofs(reg_ofs), .rdata(rdata)
  );

  task automatic check(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) addr=%h got %h expected %h", tag, fld, addr, act, exp);
    end
  endtask

  function automatic bit model_reg_hit(input int a);
    return ((a >> 12) == (m_map & 15)) && ((a & 'hFFF) < REGB);
  endfunction

  task automatic compare(input string tag);
    int a = int'(addr);
    bit rg = model_reg_hit(a);
    bit rm = !rg && ((a >> 12) == (m_map >> 4)) && ((a & 'hFFF) < RAMB);
    bit re = !rg && !rm && ee_en && (a >= EEB) && (a < EEB + EES);
    check(tag, "sel_reg R3", int'(sel_reg), int'(rg));
    check(tag, "sel_ram R2", int'(sel_ram), int'(rm));
    check(tag, "sel_ee R8",  int'(sel_ee),  int'(re));
    check(tag, "reg_ofs R3", int'(reg_ofs), rg ? (a & 'hFF) : 0);
    check(tag, "rdata R7",   int'(rdata),   (rg && (a & 'hFFF) == SLOT) ? m_map : 0);
  endtask

  task automatic step(input logic [15:0] a, input bit w, input logic [7:0] d,
                      input bit e, input string tag);
    @(negedge clk);
    addr = a; wr_en = w; wdata = d; ee_en = e;
    #1 compare(tag);
    @(posedge clk);
    if (w && model_reg_hit(int'(a)) && ((int'(a) & 'hFFF) == SLOT) && m_cnt < WIN && !m_taken) begin
      m_map = int'(d);
      m_taken = 1'b1;
    end
    if (m_cnt < WIN) m_cnt++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; ee_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    m_map = 0; m_cnt = 0; m_taken = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    do_reset();
    // R1: reset placement, both regions in page 0
    step(16'h003D, 0, 8'h00, 0, "R1");
    step(16'h0000, 0, 8'h00, 0, "R9");
    step(16'h0100, 0, 8'h00, 0, "R1");
    step(16'h0400, 0, 8'h00, 0, "R2");
    // R4: early write moves RAM to page 2 and block to page 1
    step(16'h003D, 1, 8'h21, 0, "R4");
    step(16'h103D, 0, 8'h00, 0, "R7");
    step(16'h003D, 0, 8'h00, 0, "R7");
    // R6: second write in window ignored
    step(16'h103D, 1, 8'h55, 0, "R6");
    step(16'h103D, 0, 8'h00, 0, "R6");
    step(16'h2000, 0, 8'h00, 0, "R2");
    step(16'h23FF, 0, 8'h00, 0, "R2");
    step(16'h2400, 0, 8'h00, 0, "R2");
    step(16'h1000, 0, 8'h00, 0, "R3");
    step(16'h109F, 0, 8'h00, 0, "R3");
    step(16'h10A0, 0, 8'h00, 0, "R3");
    step(16'hE000, 0, 8'h00, 0, "R8");
    step(16'hE000, 0, 8'h00, 1, "R8");
    step(16'hE7FF, 0, 8'h00, 1, "R8");
    step(16'hE800, 0, 8'h00, 1, "R8");

    // R4 boundary: write at edge index 63 accepted
    do_reset();
    for (int i = 0; i < WIN - 1; i++) step(16'h0000, 0, 8'h00, 0, "R4");
    step(16'h003D, 1, 8'hEE, 0, "R4");
    step(16'hE03D, 0, 8'h00, 0, "R4");
    checks++;
    if (rdata != 8'hEE) begin
      errors++;
      $display("FAIL R4 (last-cycle write) got %h expected ee", rdata);
    end
    // R9: all regions stacked on page E
    step(16'hE010, 0, 8'h00, 1, "R9");
    step(16'hE0A0, 0, 8'h00, 1, "R9");
    step(16'hE400, 0, 8'h00, 1, "R9");

    // R5: write at edge index 64 ignored
    do_reset();
    for (int i = 0; i < WIN; i++) step(16'h0000, 0, 8'h00, 0, "R5");
    step(16'h003D, 1, 8'h77, 0, "R5");
    step(16'h003D, 0, 8'h00, 0, "R5");
    checks++;
    if (rdata != 8'h00) begin
      errors++;
      $display("FAIL R5 (late write) got %h expected 00", rdata);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule